// File: doc/BRIEF.md
# Dual-Mode Programmable Clock Output

This block makes a single clock output from one of two sources. In crystal mode it divides a stream of enable pulses down to one of four fixed rates. The pulses arrive once per crystal half-cycle, so a 32768 Hz crystal gives 65536 pulses per second. In high-frequency mode a phase accumulator, clocked by the fast reference clock, makes an output rate of (divisor + 1) times 8192 Hz. The divisor is 13 bits wide and is split across two byte registers. A separate power-register bit forces the output low while it is set.

Software reaches the block through a byte-wide register port. The port has a single-cycle write strobe and a combinational read path. New mode, rate-code or divisor values are staged. They reach the generator only when the output next changes level, so a half-period in progress always finishes with the settings it started with. The block also has a clock flag that is set on every rising output edge, and an interrupt enable for that flag. Together they drive an active-low interrupt line.

Top module: `clkout_divider`

## Requirements
- R1: After reset, clk_out is 0 and irq_n is 1. Registers 0x0E, 0x11, 0xC0, 0xC2 and 0xC3 read 0x00, which selects crystal mode with code 0.
- R2: Only these bits are stored and read back: bit 6 of 0xC0 (output off), bit 6 of 0x11 (interrupt enable), all of 0xC2, all of 0xC3 and bit 1 of 0x0E (flag). Every other bit, and every other address, reads 0. A write cannot set the flag.
- R3: When 0xC3 bit 7 = 0 (crystal mode), 0xC3 bits 6:5 = 0, 1, 2, 3 make the output change level after every 1, 32, 512 or 32768 xtal_en pulses. Cycles with xtal_en low do not advance the count.
- R4: When 0xC3 bit 7 = 1 (high-frequency mode), the output half-period is REF_HZ / (2 x (N+1) x 8192) reference cycles, where N is the divisor and the quotient is exact.
- R5: The divisor N is {0xC3[4:0], 0xC2[7:0]}. Bit 7 of 0xC3 selects the mode.
- R6: While 0xC0 bit 6 = 1, clk_out is 0 from the second clock edge after the write onward. Clearing the bit restarts the output from 0 with the staged settings.
- R7: A change to the mode, code or divisor takes effect at the next output level change. The half-period in progress keeps its old length.
- R8: The flag (0x0E bit 1) is set in the same cycle that clk_out rises. Writing 0x0E with bit 1 = 0 clears it. Writing bit 1 = 1 has no effect.
- R9: When a rising output edge and a flag-clearing write fall on the same clock edge, the flag ends up set.
- R10: irq_n is 0 exactly when the flag and the interrupt enable (0x11 bit 6) are both 1.
- R11: A high-frequency rate at or above half the reference clock saturates, so the output changes level every reference cycle. With REF_HZ = 2^26 this happens for N = 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_en | input | 1 | One pulse per crystal half-cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational |
| clk_out | output | 1 | Generated clock |
| irq_n | output | 1 | Active-low clock interrupt |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a rising output edge that sets the flag and a software write that clears it. The second pair is a divisor write and the output level change that picks up staged settings. The bench runs the output at one level change per cycle and waits until the output is low at a falling clock edge. It then issues the clear, so that the write and the rise share the next edge, and it expects the flag to stay set. The same clear issued while the output is high must leave the flag at 0. For staging, the divisor is rewritten 100 cycles into a 1024-cycle half-period. That half-period must still measure 1024 cycles, and the following ones must measure 512.

// File: rtl/clkout_divider.sv
module clkout_divider #(
  parameter int unsigned REF_HZ  = 67108864,
  parameter int unsigned STEP_HZ = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_en,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       clk_out,
  output logic       irq_n
);
  localparam logic [7:0]  A_FLAG = 8'h0E;
  localparam logic [7:0]  A_IE   = 8'h11;
  localparam logic [7:0]  A_PWR  = 8'hC0;
  localparam logic [7:0]  A_DLO  = 8'hC2;
  localparam logic [7:0]  A_DHI  = 8'hC3;
  localparam int          XW     = 15;
  localparam int          DW     = 13;
  localparam logic [31:0] REF_V  = 32'(REF_HZ);
  localparam logic [31:0] STEP2  = 32'(2 * STEP_HZ);

  logic          off_q, ie_q, flag_q;
  logic [7:0]    dlo_q, dhi_q;
  logic [15:0]   want, act_q;
  logic [31:0]   acc_q, inc_raw, inc, sum;
  logic [XW-1:0] xcnt_q, xlast;
  logic          act_hf, hf_hit, xt_hit, tgl, clr_flag;
  logic [1:0]    act_sel;
  logic [DW-1:0] act_div;

  assign want    = {dhi_q, dlo_q};
  assign act_hf  = act_q[15];
  assign act_sel = act_q[14:13];
  assign act_div = act_q[DW-1:0];

  always_comb begin
    case (act_sel)
      2'd0:    xlast = XW'(0);
      2'd1:    xlast = XW'(31);
      2'd2:    xlast = XW'(511);
      default: xlast = XW'(32767);
    endcase
  end

  assign inc_raw = (32'(act_div) + 32'd1) * STEP2;
  assign inc     = (inc_raw > REF_V) ? REF_V : inc_raw;
  assign sum     = acc_q + inc;
  assign hf_hit  = sum >= REF_V;
  assign xt_hit  = xtal_en && (xcnt_q == xlast);
  assign tgl     = !off_q && (act_hf ? hf_hit : xt_hit);

  assign clr_flag = wr_en && (wr_addr == A_FLAG) && !wr_data[1];
  assign irq_n    = !(flag_q && ie_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= 1'b0;
      ie_q  <= 1'b0;
      dlo_q <= 8'h00;
      dhi_q <= 8'h00;
    end else if (wr_en) begin
      case (wr_addr)
        A_PWR:   off_q <= wr_data[6];
        A_IE:    ie_q  <= wr_data[6];
        A_DLO:   dlo_q <= wr_data;
        A_DHI:   dhi_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_out <= 1'b0;
      act_q   <= 16'h0000;
      acc_q   <= 32'd0;
      xcnt_q  <= '0;
    end else if (off_q) begin
      clk_out <= 1'b0;
      act_q   <= want;
      acc_q   <= 32'd0;
      xcnt_q  <= '0;
    end else if (tgl) begin
      clk_out <= !clk_out;
      xcnt_q  <= '0;
      if (want != act_q) begin
        act_q <= want;
        acc_q <= 32'd0;
      end else begin
        acc_q <= act_hf ? sum - REF_V : 32'd0;
      end
    end else if (act_hf) begin
      acc_q <= sum;
    end else if (xtal_en) begin
      xcnt_q <= xcnt_q + XW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (tgl && !clk_out)  flag_q <= 1'b1;
    else if (clr_flag)         flag_q <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      A_FLAG:  rd_data = {6'b0, flag_q, 1'b0};
      A_IE:    rd_data = {1'b0, ie_q, 6'b0};
      A_PWR:   rd_data = {1'b0, off_q, 6'b0};
      A_DLO:   rd_data = dlo_q;
      A_DHI:   rd_data = dhi_q;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/clkout_divider_sva.sv
module clkout_divider_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        xtal_en,
  input logic        clk_out,
  input logic        irq_n,
  input logic        off_q,
  input logic        flag_q,
  input logic [15:0] act_q
);
  a_r6_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |=> !clk_out);

  a_r8_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> flag_q);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> flag_q);

  a_r10_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> irq_n);

  a_r7_cfg_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(off_q) && !$stable(act_q)) |-> !$stable(clk_out));

  a_r3_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(off_q) && !$past(act_q[15]) && !$stable(clk_out)) |-> $past(xtal_en));
endmodule

bind clkout_divider clkout_divider_sva u_sva (
  .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .clk_out(clk_out),
  .irq_n(irq_n), .off_q(off_q), .flag_q(flag_q), .act_q(act_q)
);

// File: tb/clkout_divider_test.sv
module clkout_divider_test;
  localparam int unsigned REF_HZ = 67108864;
  localparam int unsigned STEP   = 8192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       clk_out, irq_n;
  int checks = 0;
  int errors = 0;

  clkout_divider #(.REF_HZ(REF_HZ), .STEP_HZ(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .clk_out(clk_out), .irq_n(irq_n)
  );

  always #2 clk = !clk;

  function automatic int hf_half(input int n);
    return int'(REF_HZ / (2 * (n + 1) * STEP));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic wait_edge();
    logic prev = clk_out;
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (clk_out == prev && n < 70000);
  endtask

  task automatic count_half(input int gap_from, input int gap_to, input int wr_at,
                            input logic [7:0] wa, input logic [7:0] wd, output int n);
    logic prev = clk_out;
    n = 0;
    do begin
      if (n == gap_from) xtal_en = 1'b0;
      if (n == gap_to) xtal_en = 1'b1;
      if (n == wr_at) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
      if (n == wr_at + 1) wr_en = 1'b0;
      @(negedge clk);
      n++;
    end while (clk_out == prev && n < 70000);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int n);
    wait_edge();
    count_half(-1, -1, -1, 8'h00, 8'h00, n);
  endtask

  task automatic t_reset();
    int d;
    chk("R1 clk_out", int'(clk_out), 0);
    chk("R1 irq_n", int'(irq_n), 1);
    foreach (d_list[i]) begin
      rd(d_list[i], d);
      chk($sformatf("R1 reg %02h", d_list[i]), d, 0);
    end
  endtask
  logic [7:0] d_list [5] = '{8'h0E, 8'h11, 8'hC0, 8'hC2, 8'hC3};

  task automatic t_regs();
    int d;
    wr(8'hC0, 8'hFF); rd(8'hC0, d); chk("R2 power mask", d, 8'h40);
    wr(8'h11, 8'hFF); rd(8'h11, d); chk("R2 ie mask", d, 8'h40);
    wr(8'hC2, 8'hA5); rd(8'hC2, d); chk("R2 div low", d, 8'hA5);
    wr(8'hC3, 8'h7F); rd(8'hC3, d); chk("R2 div high", d, 8'h7F);
    wr(8'h0E, 8'hFF); rd(8'h0E, d); chk("R2 flag not writable", d, 0);
    wr(8'h20, 8'hFF); rd(8'h20, d); chk("R2 unmapped", d, 0);
    wr(8'hC2, 8'h00); wr(8'hC3, 8'h00); wr(8'h11, 8'h00); wr(8'hC0, 8'h00);
  endtask

  task automatic t_xtal();
    int n;
    xtal_en = 1'b1;
    measure(n); chk("R3 code0", n, 1);
    wr(8'hC3, 8'h20); measure(n); chk("R3 code1", n, 32);
    count_half(10, 50, -1, 8'h00, 8'h00, n); chk("R3 pulses gated", n, 72);
    wr(8'hC3, 8'h40); measure(n); chk("R3 code2", n, 512);
    wr(8'hC3, 8'h60); measure(n); chk("R3 code3", n, 32768);
  endtask

  task automatic t_hf();
    int n;
    wr(8'hC0, 8'h40); wr(8'hC2, 8'h03); wr(8'hC3, 8'h80); wr(8'hC0, 8'h00);
    measure(n); chk("R4 N=3", n, hf_half(3));
    wait_edge();
    count_half(-1, -1, 100, 8'hC2, 8'h07, n); chk("R7 old half kept", n, hf_half(3));
    count_half(-1, -1, -1, 8'h00, 8'h00, n); chk("R7 new half", n, hf_half(7));
    wr(8'hC2, 8'h00); measure(n); chk("R4 N=0", n, hf_half(0));
    wr(8'hC2, 8'hFF); wr(8'hC3, 8'h81); measure(n); chk("R5 split N=511", n, hf_half(511));
  endtask

  task automatic t_off();
    int n, d;
    int hi = 0;
    wr(8'hC0, 8'h40);
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      if (clk_out) hi++;
      @(negedge clk);
    end
    chk("R6 held low", hi, 0);
    rd(8'hC0, d); chk("R6 off bit", d, 8'h40);
    wr(8'hC0, 8'h00); measure(n); chk("R6 resumes", n, hf_half(511));
  endtask

  task automatic t_flag();
    int n, d;
    wr(8'hC2, 8'hFF); wr(8'hC3, 8'h9F);
    measure(n); chk("R11 saturated", n, 1);
    wr(8'h11, 8'h40);
    @(negedge clk); @(negedge clk);
    rd(8'h0E, d); chk("R8 flag set", d, 8'h02);
    chk("R10 irq active", int'(irq_n), 0);
    while (clk_out) @(negedge clk);
    wr(8'h0E, 8'h00);
    rd(8'h0E, d); chk("R9 set beats clear", d, 8'h02);
    while (!clk_out) @(negedge clk);
    wr(8'h0E, 8'h00);
    rd(8'h0E, d); chk("R8 cleared", d, 0);
    chk("R10 irq released", int'(irq_n), 1);
    @(negedge clk);
    rd(8'h0E, d); chk("R8 set again", d, 8'h02);
    wr(8'h11, 8'h00);
    chk("R10 irq masked", int'(irq_n), 1);
    wr(8'hC0, 8'h40); @(negedge clk);
    wr(8'h0E, 8'hFF);
    rd(8'h0E, d); chk("R8 write one ignored", d, 8'h02);
    wr(8'h0E, 8'h00);
    rd(8'h0E, d); chk("R8 clear while off", d, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_xtal();
    t_hf();
    t_off();
    t_flag();
    finish_run();
  end

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish within 190000 cycles");
    finish_run();
  end
endmodule